// File: doc/BRIEF.md
# Banked Multichannel DMA Register Bank

This block is the register front end of a multichannel DMA engine. A host reaches it over a simple 32-bit memory-mapped bus that has separate read and write strobes. Most per-channel state is banked behind a channel-select register, so the channel control, ring base, ring length, interrupt status and interrupt enable offsets all act on whichever channel was selected last. Per-port settings are banked in the same way behind a port-select register.

The block also holds a read-only identification word, a global reset strobe, a polling configuration, and a global mask with one bit per channel. The engine reports that a descriptor is complete by pulsing one input bit per channel. The block combines the pending status, the per-channel enable and the global mask into a single interrupt line. Moving data, fetching descriptors and arbitrating between channels are handled elsewhere.

Top module: `dma_regbank_top`

## Requirements
- R1: Offset 0x08 reads the identification word: channel count in bits 26:20, port count in bits 19:16, revision (default 0x0B) in bits 4:0, all other bits zero.
- R2: The offsets 0x1C (control), 0x20 (32-bit ring base), 0x24 (ring length, low 16 bits kept), 0x28 (status) and 0x2C (interrupt enable) act only on the channel number last written to 0x18, which itself reads back.
- R3: A channel select of NCH or more, or a port select of NPORT or more, makes the banked offsets read zero and ignore writes.
- R4: Channel control keeps bit 0 (on), bit 8 (transmit) and bits 17:16 (weight). All other bits read zero.
- R5: Writing control with bit 1 set forces the on bit to 0 and makes bit 1 read 1 for exactly 4 cycles. After that it clears by itself.
- R6: A one-cycle pulse on descDone[n] sets status bit 3 of channel n, whichever channel is selected.
- R7: A write to status clears the status bits that are set in the written value (0x7E clears). A value with bit 3 clear leaves the pending bit in place.
- R8: irqOut is high exactly when some channel n has status bit 3 pending, bit 3 set in its own interrupt enable, and bit n set in the global mask at 0xF4.
- R9: Writing 1 to bit 0 of 0x10 turns every channel off, cancels channel resets, and clears every per-channel and global interrupt enable. Pending status is kept, and 0x10 reads zero.
- R10: The polling register at 0x14 keeps only bit 31 (polling on) and bit 6 (clock divided by 4).
- R11: The port control at 0x44, banked by the port select at 0x40, keeps bits 11:8 (lane swap), bit 6 (drop on failed arbitration) and bits 5:2 (burst codes). Other bits read zero.
- R12: After reset every register reads zero except the identification word, and irqOut is low.
- R13: busRdData carries the addressed value in the cycle after busRdEn and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | 8 | Byte offset |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, one cycle after busRdEn |
| descDone | input | NCH | Per-channel descriptor-complete pulse |
| irqOut | output | 1 | Combined interrupt |

## Verification
The bench writes one bank and then reads a different bank, so a select decode that aliases channels returns the wrong ring base. A select value out of range must read zero and must leave the valid banks untouched; a design that wraps the index would instead corrupt channel 1 or port 0. The channel reset bit is read on every cycle after it is set, so a countdown that is one cycle short or long, or that leaves the on bit set, shows a wrong word in a known read slot. A completion pulse is raised on a channel that is not selected, and status is cleared with a value that lacks bit 3, so a status latch that follows the select register, or that clears on any write, gives a wrong interrupt level. The global reset is checked while status is still pending, which shows whether it clears the enables and leaves the status alone.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;
  localparam logic [7:0] OFF_ID       = 8'h08;
  localparam logic [7:0] OFF_GLBCTRL  = 8'h10;
  localparam logic [7:0] OFF_POLL     = 8'h14;
  localparam logic [7:0] OFF_CHSEL    = 8'h18;
  localparam logic [7:0] OFF_CHCTRL   = 8'h1C;
  localparam logic [7:0] OFF_BASE     = 8'h20;
  localparam logic [7:0] OFF_LEN      = 8'h24;
  localparam logic [7:0] OFF_STAT     = 8'h28;
  localparam logic [7:0] OFF_INTEN    = 8'h2C;
  localparam logic [7:0] OFF_PORTSEL  = 8'h40;
  localparam logic [7:0] OFF_PORTCTRL = 8'h44;
  localparam logic [7:0] OFF_GLBIE    = 8'hF4;

  localparam logic [31:0] PORT_MASK = 32'h0000_0F7C;
  localparam int DONE_BIT = 3;

  typedef struct packed {
    logic chSel;
    logic chCtrl;
    logic base;
    logic len;
    logic stat;
    logic intEn;
    logic glbCtrl;
    logic poll;
    logic portSel;
    logic portCtrl;
    logic glbIe;
  } wrStrb_t;

  typedef enum logic [3:0] {
    RD_NONE, RD_ID, RD_POLL, RD_CHSEL, RD_CHCTRL, RD_BASE, RD_LEN,
    RD_STAT, RD_INTEN, RD_PORTSEL, RD_PORTCTRL, RD_GLBIE
  } rdSel_t;
endpackage

// File: rtl/dma_regbank_ctrl.sv
module dma_regbank_ctrl
  import dma_regbank_pkg::*;
(
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic [7:0] busAddr,
  output wrStrb_t    wrStrb,
  output rdSel_t     rdSel
);
  always_comb begin
    wrStrb = '0;
    if (busWrEn) begin
      case (busAddr)
        OFF_GLBCTRL:  wrStrb.glbCtrl  = 1'b1;
        OFF_POLL:     wrStrb.poll     = 1'b1;
        OFF_CHSEL:    wrStrb.chSel    = 1'b1;
        OFF_CHCTRL:   wrStrb.chCtrl   = 1'b1;
        OFF_BASE:     wrStrb.base     = 1'b1;
        OFF_LEN:      wrStrb.len      = 1'b1;
        OFF_STAT:     wrStrb.stat     = 1'b1;
        OFF_INTEN:    wrStrb.intEn    = 1'b1;
        OFF_PORTSEL:  wrStrb.portSel  = 1'b1;
        OFF_PORTCTRL: wrStrb.portCtrl = 1'b1;
        OFF_GLBIE:    wrStrb.glbIe    = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdSel = RD_NONE;
    if (busRdEn) begin
      case (busAddr)
        OFF_ID:       rdSel = RD_ID;
        OFF_POLL:     rdSel = RD_POLL;
        OFF_CHSEL:    rdSel = RD_CHSEL;
        OFF_CHCTRL:   rdSel = RD_CHCTRL;
        OFF_BASE:     rdSel = RD_BASE;
        OFF_LEN:      rdSel = RD_LEN;
        OFF_STAT:     rdSel = RD_STAT;
        OFF_INTEN:    rdSel = RD_INTEN;
        OFF_PORTSEL:  rdSel = RD_PORTSEL;
        OFF_PORTCTRL: rdSel = RD_PORTCTRL;
        OFF_GLBIE:    rdSel = RD_GLBIE;
        default:      rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dma_regbank_data.sv
module dma_regbank_data
  import dma_regbank_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int NPORT      = 4,
  parameter int LEN_W      = 16,
  parameter int REV        = 11,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrb_t           wrStrb,
  input  rdSel_t            rdSel,
  input  logic [31:0]       busWrData,
  input  logic [NCH-1:0]    descDone,
  output logic [31:0]       busRdData,
  output logic              irqOut,
  output logic [NCH-1:0]    chOnV,
  output logic [NCH-1:0]    rstBusyV,
  output logic [NCH-1:0]    statV,
  output logic [NCH-1:0]    ieBitV,
  output logic [NCH-1:0]    glbIeV
);
  localparam int CH_IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int PT_IDX_W = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int CNT_W    = $clog2(RST_CYCLES + 1);
  localparam logic [31:0] ID_WORD =
    (32'(NCH) << 20) | (32'(NPORT) << 16) | 32'(REV & 31);

  logic [7:0] chSel, portSel;
  logic [NCH-1:0] glbIe;
  logic pollOn, pollDiv;
  logic chValid, portValid;
  logic [CH_IDX_W-1:0] chIdx;
  logic [PT_IDX_W-1:0] ptIdx;
  logic glbRst;

  logic [31:0] ctrlWord [NCH];
  logic [31:0] baseWord [NCH];
  logic [31:0] lenWord  [NCH];
  logic [31:0] ieWord   [NCH];
  logic [31:0] portWord [NPORT];

  assign chValid   = 32'(chSel) < NCH;
  assign portValid = 32'(portSel) < NPORT;
  assign chIdx     = chSel[CH_IDX_W-1:0];
  assign ptIdx     = portSel[PT_IDX_W-1:0];
  assign glbRst    = wrStrb.glbCtrl && busWrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chSel <= '0; portSel <= '0; glbIe <= '0; pollOn <= 1'b0; pollDiv <= 1'b0;
    end else begin
      if (wrStrb.chSel)   chSel   <= busWrData[7:0];
      if (wrStrb.portSel) portSel <= busWrData[7:0];
      if (wrStrb.poll) begin
        pollOn  <= busWrData[31];
        pollDiv <= busWrData[6];
      end
      if (glbRst)            glbIe <= '0;
      else if (wrStrb.glbIe) glbIe <= busWrData[NCH-1:0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic onQ, txQ, statQ;
    logic [1:0] wtQ;
    logic [31:0] baseQ;
    logic [LEN_W-1:0] lenQ;
    logic [7:0] ieQ;
    logic [CNT_W-1:0] cntQ;
    logic hit;
    assign hit = chValid && (chIdx == CH_IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        onQ <= 1'b0; txQ <= 1'b0; wtQ <= '0; ieQ <= '0; cntQ <= '0;
      end else if (glbRst) begin
        onQ <= 1'b0; ieQ <= '0; cntQ <= '0;
      end else begin
        if (cntQ != '0) cntQ <= cntQ - 1'b1;
        if (hit && wrStrb.chCtrl) begin
          txQ <= busWrData[8];
          wtQ <= busWrData[17:16];
          if (busWrData[1]) begin
            onQ  <= 1'b0;
            cntQ <= CNT_W'(RST_CYCLES);
          end else begin
            onQ <= busWrData[0];
          end
        end
        if (hit && wrStrb.intEn) ieQ <= busWrData[7:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ <= '0; lenQ <= '0; statQ <= 1'b0;
      end else begin
        if (hit && wrStrb.base) baseQ <= busWrData;
        if (hit && wrStrb.len)  lenQ  <= busWrData[LEN_W-1:0];
        if (descDone[i])        statQ <= 1'b1;
        else if (hit && wrStrb.stat && busWrData[DONE_BIT]) statQ <= 1'b0;
      end
    end

    assign ctrlWord[i] = {14'b0, wtQ, 7'b0, txQ, 6'b0, (cntQ != '0), onQ};
    assign baseWord[i] = baseQ;
    assign lenWord[i]  = 32'(lenQ);
    assign ieWord[i]   = {24'b0, ieQ};
    assign chOnV[i]    = onQ;
    assign rstBusyV[i] = (cntQ != '0);
    assign statV[i]    = statQ;
    assign ieBitV[i]   = ieQ[DONE_BIT];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [31:0] ctrlQ;
    always_ff @(posedge clk) begin
      if (!rstN) ctrlQ <= '0;
      else if (portValid && ptIdx == PT_IDX_W'(p) && wrStrb.portCtrl)
        ctrlQ <= busWrData & PORT_MASK;
    end
    assign portWord[p] = ctrlQ;
  end

  logic [31:0] rdMux;
  always_comb begin
    rdMux = '0;
    case (rdSel)
      RD_ID:       rdMux = ID_WORD;
      RD_POLL:     rdMux = {pollOn, 24'b0, pollDiv, 6'b0};
      RD_CHSEL:    rdMux = {24'b0, chSel};
      RD_PORTSEL:  rdMux = {24'b0, portSel};
      RD_GLBIE:    rdMux = 32'(glbIe);
      RD_CHCTRL:   if (chValid) rdMux = ctrlWord[chIdx];
      RD_BASE:     if (chValid) rdMux = baseWord[chIdx];
      RD_LEN:      if (chValid) rdMux = lenWord[chIdx];
      RD_INTEN:    if (chValid) rdMux = ieWord[chIdx];
      RD_STAT:     if (chValid) rdMux = 32'(statV[chIdx]) << DONE_BIT;
      RD_PORTCTRL: if (portValid) rdMux = portWord[ptIdx];
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdData <= '0;
    else       busRdData <= rdMux;
  end

  assign glbIeV = glbIe;
  assign irqOut = |(statV & ieBitV & glbIe);
endmodule

// File: rtl/dma_regbank_top.sv
module dma_regbank_top
  import dma_regbank_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int NPORT      = 4,
  parameter int LEN_W      = 16,
  parameter int REV        = 11,
  parameter int RST_CYCLES = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           busWrEn,
  input  logic           busRdEn,
  input  logic [7:0]     busAddr,
  input  logic [31:0]    busWrData,
  output logic [31:0]    busRdData,
  input  logic [NCH-1:0] descDone,
  output logic           irqOut
);
  wrStrb_t wrStrb;
  rdSel_t  rdSel;
  logic [NCH-1:0] chOnV, rstBusyV, statV, ieBitV, glbIeV;

  dma_regbank_ctrl u_ctrl (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .wrStrb(wrStrb), .rdSel(rdSel)
  );

  dma_regbank_data #(
    .NCH(NCH), .NPORT(NPORT), .LEN_W(LEN_W), .REV(REV), .RST_CYCLES(RST_CYCLES)
  ) u_data (
    .clk(clk), .rstN(rstN), .wrStrb(wrStrb), .rdSel(rdSel),
    .busWrData(busWrData), .descDone(descDone), .busRdData(busRdData),
    .irqOut(irqOut), .chOnV(chOnV), .rstBusyV(rstBusyV), .statV(statV),
    .ieBitV(ieBitV), .glbIeV(glbIeV)
  );
endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           busWrEn,
  input logic           busRdEn,
  input logic [7:0]     busAddr,
  input logic [31:0]    busWrData,
  input logic [31:0]    busRdData,
  input logic [NCH-1:0] descDone,
  input logic           irqOut,
  input logic [NCH-1:0] chOnV,
  input logic [NCH-1:0] rstBusyV,
  input logic [NCH-1:0] statV,
  input logic [NCH-1:0] ieBitV,
  input logic [NCH-1:0] glbIeV
);
  p_idle_rd_zero_r13: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> busRdData == 32'h0);

  p_glbrst_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 8'h10 && busWrData[0])
      |=> (chOnV == '0 && ieBitV == '0 && glbIeV == '0 && !irqOut));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_done_sets_stat_r6: assert property (@(posedge clk) disable iff (!rstN)
      descDone[i] |=> statV[i]);
    p_rst_forces_off_r5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rstBusyV[i]) |-> !chOnV[i]);
    p_rst_lasts_r5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rstBusyV[i]) |=> rstBusyV[i]);
    p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
      (statV[i] && ieBitV[i] && glbIeV[i]) |-> irqOut);
  end
endmodule

bind dma_regbank_top dma_regbank_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
  .descDone(descDone), .irqOut(irqOut), .chOnV(chOnV),
  .rstBusyV(rstBusyV), .statV(statV), .ieBitV(ieBitV), .glbIeV(glbIeV)
);

// File: tb/tb_dma_regbank_top.sv
`timescale 1ns/1ps
module tb_dma_regbank_top;
  localparam int NCH = 8;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [NCH-1:0] descDone = '0;
  logic irqOut;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  typedef struct { logic [31:0] exp; string tag; } expItem_t;
  expItem_t sbQ[$];
  logic rdCapt = 1'b0;

  always #2 clk = ~clk;

  dma_regbank_top dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .descDone(descDone), .irqOut(irqOut)
  );

  task automatic checkEq(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    expItem_t it;
    it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic pulseDone(input int ch);
    descDone[ch] = 1'b1;
    @(negedge clk);
    descDone = '0;
  endtask

  always @(posedge clk) rdCapt <= busRdEn;

  always @(negedge clk) begin
    if (rdCapt) begin
      if (sbQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R13: actual unexpected read expected none");
      end else begin
        expItem_t it;
        it = sbQ.pop_front();
        checkEq(busRdData, it.exp, it.tag);
      end
    end else if (rstN) begin
      if (busRdData !== 32'h0) begin
        nChecks++; nFails++;
        $display("FAIL R13: actual 0x%08h expected 0x00000000 when idle", busRdData);
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    checkEq(32'(irqOut), 0, "R12 irq after reset");
    rd(8'h18, 32'h0, "R12 chan select");
    rd(8'h20, 32'h0, "R12 base ch0");
    rd(8'h14, 32'h0, "R12 poll");
    // R1 identification
    rd(8'h08, 32'h0084_000B, "R1 id word");

    // R2 banking
    wr(8'h18, 2); wr(8'h20, 32'h0000_1000); wr(8'h24, 32'h0001_2345);
    wr(8'h18, 5); wr(8'h20, 32'h0000_2000);
    rd(8'h18, 32'h5, "R2 select readback");
    rd(8'h20, 32'h0000_2000, "R2 base ch5");
    rd(8'h24, 32'h0, "R2 len ch5");
    wr(8'h18, 2);
    rd(8'h20, 32'h0000_1000, "R2 base ch2");
    rd(8'h24, 32'h0000_2345, "R2 len ch2");

    // R3 out-of-range channel select
    wr(8'h18, 9); wr(8'h20, 32'hDEAD_BEEF);
    rd(8'h20, 32'h0, "R3 base out of range");
    wr(8'h18, 1);
    rd(8'h20, 32'h0, "R3 ch1 untouched");
    wr(8'h18, 2);
    rd(8'h20, 32'h0000_1000, "R3 ch2 untouched");

    // R4 control fields
    wr(8'h18, 6); wr(8'h1C, 32'hFFFE_FFFD);
    rd(8'h1C, 32'h0002_0101, "R4 ctrl mask");

    // R5 self-clearing channel reset
    wr(8'h18, 3); wr(8'h1C, 32'h0001_0101);
    rd(8'h1C, 32'h0001_0101, "R5 on before reset");
    wr(8'h1C, 32'h0001_0103);
    for (int k = 0; k < 4; k++) rd(8'h1C, 32'h0001_0102, "R5 reset busy");
    rd(8'h1C, 32'h0001_0100, "R5 reset done");

    // R6/R8 interrupt path
    wr(8'h18, 4); wr(8'h2C, 32'h8); wr(8'hF4, 32'h10);
    wr(8'h18, 2);
    checkEq(32'(irqOut), 0, "R8 idle");
    pulseDone(4);
    checkEq(32'(irqOut), 1, "R8 irq raised");
    wr(8'h18, 4);
    rd(8'h28, 32'h8, "R6 status ch4");
    wr(8'hF4, 32'h01);
    checkEq(32'(irqOut), 0, "R8 global mask");
    wr(8'hF4, 32'h10); wr(8'h2C, 32'h0);
    checkEq(32'(irqOut), 0, "R8 channel mask");
    wr(8'h2C, 32'h8);
    checkEq(32'(irqOut), 1, "R8 re-enabled");

    // R7 write-to-clear
    wr(8'h28, 32'h4);
    rd(8'h28, 32'h8, "R7 clear without bit3");
    wr(8'h28, 32'h7E);
    checkEq(32'(irqOut), 0, "R7 irq after clear");
    rd(8'h28, 32'h0, "R7 status cleared");

    // R9 global reset with status pending
    pulseDone(4);
    checkEq(32'(irqOut), 1, "R9 irq before global reset");
    wr(8'h10, 32'h1);
    checkEq(32'(irqOut), 0, "R9 irq after global reset");
    rd(8'h2C, 32'h0, "R9 chan enable cleared");
    rd(8'hF4, 32'h0, "R9 global enable cleared");
    rd(8'h28, 32'h8, "R9 status kept");
    rd(8'h10, 32'h0, "R9 global ctrl reads zero");
    wr(8'h18, 6);
    rd(8'h1C, 32'h0002_0100, "R9 channel turned off");

    // R10 polling
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, 32'h8000_0040, "R10 poll mask");

    // R11 port control and R3 port range
    wr(8'h40, 1); wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h40, 3); wr(8'h44, 32'h0000_0014);
    rd(8'h44, 32'h0000_0014, "R11 port3");
    wr(8'h40, 1);
    rd(8'h44, 32'h0000_0F7C, "R11 port1 mask");
    wr(8'h40, 4); wr(8'h44, 32'h0000_0F00);
    rd(8'h44, 32'h0, "R3 port out of range");
    wr(8'h40, 0);
    rd(8'h44, 32'h0, "R3 port0 untouched");

    repeat (3) @(negedge clk);
    if (sbQ.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL R13: actual %0d reads pending expected 0", sbQ.size());
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule